// File: doc/BRIEF.md
# Writeback Port Reservation Checker

This block sits at the issue stage of a pipeline with two execution paths of different depth. The short path (integer execute, then memory access) takes an instruction to writeback `INT_LAT` cycles after it leaves decode. The long path (three floating-point execute stages) takes `FP_LAT` cycles. The register file has one write port for integer registers and one for floating-point registers. Either path may target either class of register. A floating-point load, for example, travels the short path but writes a floating-point register. Two writes to the same class must never land in the same cycle.

The checker keeps one reservation shift register per register class. Bit k of each register means that a write of that class lands k cycles from now. Every cycle the bits move one step toward writeback. An instruction in decode presents `in_valid`, the path it will take and its destination class. `in_ready` is computed combinationally from those inputs and the current reservations. It drops when the slot the instruction would need is already taken. The instruction is issued on a clock edge where `in_valid` and `in_ready` are both high, and only then does it claim its slot.

Back-pressure rules: a stalled instruction must hold its fields stable until it is accepted. An instruction that was issued earlier always keeps its slot. Resolving a collision only ever delays the younger instruction in decode. `in_ready` is high whenever `in_valid` is low. Both latencies must be at least 2.

Top module: `wb_port_checker`

## Requirements
- R1: After reset both reservation vectors are all zero, and `in_ready` is high.
- R2: A short-path instruction with a destination, accepted in cycle t, sets the bit of its class that lands at t+INT_LAT. One cycle after acceptance this is bit INT_LAT-1 of the vector (bit 1 is the least significant bit).
- R3: A long-path instruction with a destination, accepted in cycle t, sets the bit of its class that lands at t+FP_LAT. One cycle after acceptance this is bit FP_LAT-1.
- R4: Each cycle every reservation bit moves from position k to position k-1. Bit 1 is dropped. The top bit fills with zero unless a new claim is made.
- R5: With `in_valid` and a destination, `in_ready` is low exactly when bit L of the destination class vector is set, where L is the latency of the chosen path. A stalled instruction claims nothing.
- R6: An instruction with `in_has_dest` low never stalls and claims no slot.
- R7: Reservations of one class never stall an instruction whose destination is of the other class.
- R8: Back-to-back instructions on the same path with the same class never collide.
- R9: While `in_valid` is low, `in_ready` is high and no slot is claimed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present in decode |
| in_ready | output | 1 | Instruction may issue this cycle (low = stall) |
| in_fp_pipe | input | 1 | 1 = long floating-point path, 0 = short path |
| in_has_dest | input | 1 | Instruction writes a register |
| in_dest_fp | input | 1 | 1 = destination is a floating-point register, 0 = integer |
| int_resv | output | MAX_LAT | Integer-port reservations, bit k = write in k cycles |
| fp_resv | output | MAX_LAT | Floating-point-port reservations, bit k = write in k cycles |

## Verification
The bench builds the block with its defaults, a short-path latency of 3 and a long-path latency of 4, so the vectors are four bits wide. With the paths one cycle apart, a floating-point add followed directly by a floating-point load produces the collision. The bench checks that the load waits exactly one cycle and then shares the vector with the add in adjacent slots. The same latencies let cross-class pairs, destination-free instructions and idle cycles sit on top of live reservations, where a wrong probe would show up.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic {
    CLS_INT = 1'b0,
    CLS_FP  = 1'b1
  } wb_class_e;

  localparam int NUM_CLASSES = 2;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/wbc_lat_sel.sv
module wbc_lat_sel #(
  parameter int INT_LAT = 3,
  parameter int FP_LAT  = 4,
  parameter int LW      = 3
) (
  input  logic          fp_pipe,
  output logic [LW-1:0] lat
);
  localparam logic [LW-1:0] INT_L = LW'(INT_LAT);
  localparam logic [LW-1:0] FP_L  = LW'(FP_LAT);

  assign lat = fp_pipe ? FP_L : INT_L;
endmodule

// File: rtl/wbc_slot_track.sv
module wbc_slot_track #(
  parameter int MAX_LAT = 4,
  parameter int LW      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             claim,
  input  logic [LW-1:0]    claim_lat,
  input  logic [LW-1:0]    probe_lat,
  output logic             hit,
  output logic [MAX_LAT:1] resv
);
  logic [MAX_LAT:1] ahead, ahead_nxt;

  for (genvar k = 1; k <= MAX_LAT; k++) begin : g_slot
    logic from_above;
    if (k < MAX_LAT) begin : g_mid
      assign from_above = ahead[k+1];
    end else begin : g_top
      assign from_above = 1'b0;
    end
    assign ahead_nxt[k] = from_above | (claim && (claim_lat == LW'(k + 1)));
  end

  always_comb begin
    hit = 1'b0;
    for (int k = 1; k <= MAX_LAT; k++) begin
      if (probe_lat == LW'(k)) hit = ahead[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ahead <= '0;
    else        ahead <= ahead_nxt;
  end

  assign resv = ahead;

  for (genvar k = 1; k < MAX_LAT; k++) begin : g_chk
    assert_slot_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ahead[k+1] |=> ahead[k]);
  end
  assert_claim_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (claim && claim_lat >= LW'(2) && claim_lat <= LW'(MAX_LAT + 1))
      |=> (($countones(ahead) >= 1)));
endmodule

// File: rtl/wb_port_checker.sv
module wb_port_checker #(
  parameter int INT_LAT = 3,
  parameter int FP_LAT  = 4,
  localparam int MAX_LAT = wbc_pkg::max_of(INT_LAT, FP_LAT),
  localparam int LW      = $clog2(MAX_LAT + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_fp_pipe,
  input  logic             in_has_dest,
  input  logic             in_dest_fp,
  output logic [MAX_LAT:1] int_resv,
  output logic [MAX_LAT:1] fp_resv
);
  import wbc_pkg::*;

  logic [LW-1:0] lat;
  logic [NUM_CLASSES-1:0] cls_hit;
  logic [NUM_CLASSES-1:0] cls_claim;
  logic [MAX_LAT:1] cls_resv [NUM_CLASSES];
  wb_class_e dest_cls;
  logic conflict, accept;

  wbc_lat_sel #(.INT_LAT(INT_LAT), .FP_LAT(FP_LAT), .LW(LW)) u_lat (
    .fp_pipe (in_fp_pipe),
    .lat     (lat)
  );

  assign dest_cls = in_dest_fp ? CLS_FP : CLS_INT;
  assign conflict = in_valid && in_has_dest && cls_hit[dest_cls];
  assign in_ready = !conflict;
  assign accept   = in_valid && in_ready && in_has_dest;

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : g_cls
    assign cls_claim[c] = accept && (dest_cls == wb_class_e'(c));
    wbc_slot_track #(.MAX_LAT(MAX_LAT), .LW(LW)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .claim     (cls_claim[c]),
      .claim_lat (lat),
      .probe_lat (lat),
      .hit       (cls_hit[c]),
      .resv      (cls_resv[c])
    );
  end

  assign int_resv = cls_resv[CLS_INT];
  assign fp_resv  = cls_resv[CLS_FP];

  assert_idle_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |-> in_ready);
  assert_nodest_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_has_dest) |-> in_ready);
  assert_short_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_has_dest && !in_fp_pipe && !in_dest_fp)
      |=> int_resv[INT_LAT-1]);
  assert_long_claim_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_has_dest && in_fp_pipe && in_dest_fp)
      |=> fp_resv[FP_LAT-1]);
  assert_single_claim_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cls_claim));
endmodule

// File: tb/wb_port_checker_test.sv
module wb_port_checker_test;
  localparam int INT_LAT = 3;
  localparam int FP_LAT  = 4;
  localparam int ML      = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_fp_pipe = 1'b0, in_has_dest = 1'b0, in_dest_fp = 1'b0;
  logic in_ready;
  logic [ML:1] int_resv, fp_resv;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wb_port_checker #(.INT_LAT(INT_LAT), .FP_LAT(FP_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_fp_pipe(in_fp_pipe), .in_has_dest(in_has_dest), .in_dest_fp(in_dest_fp),
    .int_resv(int_resv), .fp_resv(fp_resv)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive after a falling edge, let combinational ready settle
  task automatic drive(input logic v, input logic fpp, input logic hd, input logic dfp);
    in_valid = v; in_fp_pipe = fpp; in_has_dest = hd; in_dest_fp = dfp;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic flush();
    drive(0, 0, 0, 0);
    repeat (ML + 1) step();
  endtask

  task automatic t_reset();
    chk("R1 int_resv", 8'(int_resv), 8'h0);
    chk("R1 fp_resv", 8'(fp_resv), 8'h0);
    chk("R1 ready", 8'(in_ready), 8'h1);
  endtask

  task automatic t_short();
    drive(1, 0, 1, 0);
    chk("R2 ready", 8'(in_ready), 8'h1);
    step(); drive(0, 0, 0, 0);
    chk("R2 int slot", 8'(int_resv), 8'h2);
    step();
    chk("R4 int shift", 8'(int_resv), 8'h1);
    step();
    chk("R4 int drop", 8'(int_resv), 8'h0);
  endtask

  task automatic t_long();
    drive(1, 1, 1, 1);
    step(); drive(0, 0, 0, 0);
    chk("R3 fp slot", 8'(fp_resv), 8'h4);
    step();
    chk("R4 fp shift", 8'(fp_resv), 8'h2);
    flush();
  endtask

  task automatic t_collide();
    drive(1, 1, 1, 1);           // long-path add, fp dest
    step(); drive(1, 0, 1, 1);   // short-path load, fp dest
    chk("R5 stall", 8'(in_ready), 8'h0);
    step();
    chk("R5 no claim while stalled", 8'(fp_resv), 8'h2);
    chk("R5 released", 8'(in_ready), 8'h1);
    step(); drive(0, 0, 0, 0);
    chk("R5 both held", 8'(fp_resv), 8'h3);
    flush();
  endtask

  task automatic t_cross();
    drive(1, 1, 1, 1);
    step(); drive(1, 0, 1, 0);
    chk("R7 other class ready", 8'(in_ready), 8'h1);
    step(); drive(0, 0, 0, 0);
    chk("R7 int slot", 8'(int_resv), 8'h2);
    chk("R7 fp slot", 8'(fp_resv), 8'h2);
    flush();
  endtask

  task automatic t_same_path();
    drive(1, 0, 1, 0);
    step();
    chk("R8 second ready", 8'(in_ready), 8'h1);
    step(); drive(0, 0, 0, 0);
    chk("R8 adjacent slots", 8'(int_resv), 8'h3);
    flush();
  endtask

  task automatic t_nodest();
    drive(1, 1, 1, 1);
    step(); drive(1, 0, 0, 1);
    chk("R6 ready", 8'(in_ready), 8'h1);
    step(); drive(0, 0, 0, 0);
    chk("R6 no claim", 8'(fp_resv), 8'h2);
    flush();
  endtask

  task automatic t_idle();
    drive(1, 1, 1, 1);
    step(); drive(0, 0, 1, 1);
    chk("R9 ready idle", 8'(in_ready), 8'h1);
    step();
    chk("R9 no claim", 8'(fp_resv), 8'h2);
    flush();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    #1;
    t_reset();
    t_short();
    t_long();
    t_collide();
    t_cross();
    t_same_path();
    t_nodest();
    t_idle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule